// File: doc/BRIEF.md
# Capture/Compare/PWM Timer Channel

This block is a single channel that hangs off a shared up-counting or up/down timebase. The timebase is outside the block. The channel sees only the current count and a one-cycle step pulse that marks the first cycle a new count value is present. Its mode picks one of three functions:
- Input capture: it records the count when a chosen edge arrives on an asynchronous pin.
- Output compare: when the count reaches the channel value, it sets, clears or toggles its output pin.
- Pulse-width modulation: it drives a pulse whose width is set by the channel value, with selectable polarity.

In PWM mode the channel value is double-buffered. Software writes go into a holding register. That register is copied into the active compare register only when the count passes through zero. Zero is the wrap point of an up-counting timebase and the trough of an up/down timebase, so a width change never cuts a period short. When the timebase counts up and down, the same comparison yields a center-aligned pulse that is symmetric about the trough.

A sticky event flag records every capture and every compare match. Writing a one clears it. The flag raises an interrupt request when its enable is set.

Top module: `ccp_channel`

## Requirements
- R1: `mode` 2'b00 selects capture and 2'b01 selects compare; 2'b10 and 2'b11 both select PWM. `val_rdata` returns the active register in capture and compare modes, and the holding register in PWM mode.
- R2: In capture mode, `cap_edge` 2'b01 selects rising edges, 2'b10 falling edges, 2'b11 both and 2'b00 none. The pin passes through two synchronising flops. The active register loads the count of the cycle in which the synchronised edge is seen, which is two clock edges after the pin is first sampled. A transition that is not selected changes neither the register nor the flag.
- R3: In compare mode, a match is a step cycle whose count equals the active value. On a match, `cmp_act` 2'b01 toggles `ch_out`, 2'b10 clears it, 2'b11 sets it and 2'b00 leaves it unchanged.
- R4: In PWM mode, at each step `ch_out` becomes (count < active value) XOR `pwm_lowtrue`. The new level is visible after that clock edge.
- R5: A PWM value of 0 keeps the output inactive for every count. A value above every count the timebase reaches keeps it active for every count. Low-true polarity inverts both.
- R6: In PWM mode, a bus write reaches only the holding register. The active register takes the holding value in a step cycle with count 0, and the comparison in that same cycle already uses the new value.
- R7: With an up/down timebase, PWM value V gives an output that is active for counts below V on both slopes. The pulse is therefore symmetric about the count-0 trough.
- R8: `ch_flag` sets on a selected capture edge, and on a match in compare or PWM mode. A `flag_wr1c` pulse clears it. If a set and a clear fall in the same cycle, the set wins.
- R9: `ch_irq` is high exactly when `ch_flag` and `irq_en` are both high.
- R10: In capture and compare modes, a bus write loads the active register directly, one clock after the write.
- R11: After reset, `ch_out`, `ch_flag`, `ch_irq` and `val_rdata` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tb_count | input | CNT_W | Current timebase count |
| tb_step | input | 1 | First cycle of a new count value |
| mode | input | 2 | Function select |
| cap_edge | input | 2 | Capture edge select |
| cmp_act | input | 2 | Compare match action |
| pwm_lowtrue | input | 1 | PWM output inverted when 1 |
| val_wr | input | 1 | Channel value write strobe |
| val_wdata | input | CNT_W | Channel value write data |
| flag_wr1c | input | 1 | Flag clear strobe |
| irq_en | input | 1 | Interrupt enable |
| cap_pin | input | 1 | Asynchronous capture input |
| ch_out | output | 1 | Channel output pin |
| val_rdata | output | CNT_W | Channel value readback |
| ch_flag | output | 1 | Event flag |
| ch_irq | output | 1 | Interrupt request |

## Verification
The bench builds the channel with the default 16-bit count and a two-flop synchroniser. Because the count is full width, the all-ones value can serve as the 100% duty case, and the capture latency of exactly two edges can be checked against a count that changes every cycle. The bench drives the count itself. This lets it walk a triangular up/down sequence to show the center-aligned symmetry without needing a timebase model.

// File: rtl/ccp_pkg.sv
package ccp_pkg;
   typedef enum logic [1:0] {
      CCP_CAPTURE = 2'b00,
      CCP_COMPARE = 2'b01,
      CCP_PWM     = 2'b10,
      CCP_PWM_ALT = 2'b11
   } ccp_mode_e;

   typedef enum logic [1:0] {
      EDGE_OFF  = 2'b00,
      EDGE_RISE = 2'b01,
      EDGE_FALL = 2'b10,
      EDGE_BOTH = 2'b11
   } ccp_edge_e;

   typedef enum logic [1:0] {
      ACT_HOLD   = 2'b00,
      ACT_TOGGLE = 2'b01,
      ACT_CLEAR  = 2'b10,
      ACT_SET    = 2'b11
   } ccp_act_e;

   function automatic logic mode_is_pwm(input logic [1:0] m);
      return m[1];
   endfunction

   function automatic logic mode_is_capture(input logic [1:0] m);
      return m == CCP_CAPTURE;
   endfunction
endpackage

// File: rtl/ccp_cap_detect.sv
module ccp_cap_detect
   import ccp_pkg::*;
#(
   parameter int STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       pin,
   input  logic [1:0] sel,
   output logic       hit
);
   localparam int CHAIN = STAGES + 1;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("ccp_cap_detect: STAGES must be at least 2");
      end
   endgenerate

   logic [CHAIN-1:0] chain_q;
   logic             cur, prev, rise, fall;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[CHAIN-2:0], pin};
   end

   assign cur  = chain_q[STAGES-1];
   assign prev = chain_q[STAGES];
   assign rise = cur & ~prev;
   assign fall = ~cur & prev;

   always_comb begin
      unique case (sel)
         EDGE_RISE: hit = rise;
         EDGE_FALL: hit = fall;
         EDGE_BOTH: hit = rise | fall;
         default:   hit = 1'b0;
      endcase
   end
endmodule

// File: rtl/ccp_value_reg.sv
module ccp_value_reg #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pwm,
   input  logic             wr,
   input  logic [CNT_W-1:0] wdata,
   input  logic             cap_load,
   input  logic [CNT_W-1:0] count,
   input  logic             boundary,
   output logic [CNT_W-1:0] act_q,
   output logic [CNT_W-1:0] act_eff,
   output logic [CNT_W-1:0] hold_q
);
   generate
      if (CNT_W < 2) begin : g_bad_width
         $error("ccp_value_reg: CNT_W must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  hold_q <= '0;
      else if (wr) hold_q <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q <= '0;
      end else if (pwm) begin
         if (boundary) act_q <= hold_q;
      end else if (cap_load) begin
         act_q <= count;
      end else if (wr) begin
         act_q <= wdata;
      end
   end

   assign act_eff = (pwm && boundary) ? hold_q : act_q;
endmodule

// File: rtl/ccp_out_gen.sv
module ccp_out_gen
   import ccp_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       mode,
   input  logic [1:0]       act_code,
   input  logic             lowtrue,
   input  logic             step,
   input  logic [CNT_W-1:0] count,
   input  logic [CNT_W-1:0] cmp_val,
   output logic             pin_q,
   output logic             match
);
   logic below;
   logic pin_d;

   assign match = step && (count == cmp_val);
   assign below = count < cmp_val;

   always_comb begin
      pin_d = pin_q;
      if (mode_is_pwm(mode)) begin
         if (step) pin_d = below ^ lowtrue;
      end else if (mode == CCP_COMPARE && match) begin
         unique case (act_code)
            ACT_TOGGLE: pin_d = ~pin_q;
            ACT_CLEAR:  pin_d = 1'b0;
            ACT_SET:    pin_d = 1'b1;
            default:    pin_d = pin_q;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pin_q <= 1'b0;
      else        pin_q <= pin_d;
   end
endmodule

// File: rtl/ccp_channel.sv
module ccp_channel
   import ccp_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] tb_count,
   input  logic             tb_step,
   input  logic [1:0]       mode,
   input  logic [1:0]       cap_edge,
   input  logic [1:0]       cmp_act,
   input  logic             pwm_lowtrue,
   input  logic             val_wr,
   input  logic [CNT_W-1:0] val_wdata,
   input  logic             flag_wr1c,
   input  logic             irq_en,
   input  logic             cap_pin,
   output logic             ch_out,
   output logic [CNT_W-1:0] val_rdata,
   output logic             ch_flag,
   output logic             ch_irq
);
   logic             pwm_mode, cap_mode;
   logic             cap_hit, cap_load, boundary, match, event_set;
   logic [CNT_W-1:0] act_q, act_eff, hold_q;

   assign pwm_mode = mode_is_pwm(mode);
   assign cap_mode = mode_is_capture(mode);
   assign boundary = tb_step && (tb_count == '0);

   ccp_cap_detect #(.STAGES(SYNC_STAGES)) u_cap (
      .clk   (clk),
      .rst_n (rst_n),
      .pin   (cap_pin),
      .sel   (cap_edge),
      .hit   (cap_hit)
   );

   assign cap_load = cap_mode && cap_hit;

   ccp_value_reg #(.CNT_W(CNT_W)) u_val (
      .clk      (clk),
      .rst_n    (rst_n),
      .pwm      (pwm_mode),
      .wr       (val_wr),
      .wdata    (val_wdata),
      .cap_load (cap_load),
      .count    (tb_count),
      .boundary (boundary),
      .act_q    (act_q),
      .act_eff  (act_eff),
      .hold_q   (hold_q)
   );

   ccp_out_gen #(.CNT_W(CNT_W)) u_out (
      .clk      (clk),
      .rst_n    (rst_n),
      .mode     (mode),
      .act_code (cmp_act),
      .lowtrue  (pwm_lowtrue),
      .step     (tb_step),
      .count    (tb_count),
      .cmp_val  (act_eff),
      .pin_q    (ch_out),
      .match    (match)
   );

   assign event_set = cap_load || (!cap_mode && match);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         ch_flag <= 1'b0;
      else if (event_set) ch_flag <= 1'b1;
      else if (flag_wr1c) ch_flag <= 1'b0;
   end

   assign ch_irq    = ch_flag & irq_en;
   assign val_rdata = pwm_mode ? hold_q : act_q;
endmodule

// File: rtl/ccp_channel_chk.sv
module ccp_channel_chk #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic [1:0]       mode,
   input logic [1:0]       cmp_act,
   input logic             pwm_lowtrue,
   input logic             tb_step,
   input logic [CNT_W-1:0] tb_count,
   input logic             flag_wr1c,
   input logic             irq_en,
   input logic [CNT_W-1:0] act_q,
   input logic             ch_out,
   input logic             ch_flag,
   input logic             ch_irq
);
   a_r3_set_on_match: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b01 && cmp_act == 2'b11 && tb_step && tb_count == act_q) |=> ch_out);

   a_r3_clear_on_match: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b01 && cmp_act == 2'b10 && tb_step && tb_count == act_q) |=> !ch_out);

   a_r3_toggle_on_match: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b01 && cmp_act == 2'b01 && tb_step && tb_count == act_q) |=> (ch_out != $past(ch_out)));

   a_r6_active_held: assert property (@(posedge clk) disable iff (!rst_n)
      (mode[1] && !(tb_step && tb_count == '0)) |=> (act_q == $past(act_q)));

   a_r5_zero_duty: assert property (@(posedge clk) disable iff (!rst_n)
      (mode[1] && tb_step && tb_count != '0 && act_q == '0 && !pwm_lowtrue) |=> !ch_out);

   a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_flag && !flag_wr1c) |=> ch_flag);

   a_r9_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
      ch_irq |-> (ch_flag && irq_en));
endmodule

bind ccp_channel ccp_channel_chk #(.CNT_W(CNT_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .mode        (mode),
   .cmp_act     (cmp_act),
   .pwm_lowtrue (pwm_lowtrue),
   .tb_step     (tb_step),
   .tb_count    (tb_count),
   .flag_wr1c   (flag_wr1c),
   .irq_en      (irq_en),
   .act_q       (act_q),
   .ch_out      (ch_out),
   .ch_flag     (ch_flag),
   .ch_irq      (ch_irq)
);

// File: tb/ccp_channel_tb.sv
module ccp_channel_tb;
   localparam int CLK_PERIOD = 10;
   localparam int W = 16;

   typedef struct packed {
      logic         lt;
      logic [W-1:0] val;
      logic [W-1:0] cnt;
      logic         exp;
   } vec_t;

   localparam vec_t VEC [8] = '{
      '{1'b0, 16'd5,      16'd3,      1'b1},
      '{1'b0, 16'd5,      16'd5,      1'b0},
      '{1'b0, 16'd5,      16'd9,      1'b0},
      '{1'b1, 16'd5,      16'd3,      1'b0},
      '{1'b1, 16'd5,      16'd7,      1'b1},
      '{1'b0, 16'd0,      16'd0,      1'b0},
      '{1'b0, 16'hFFFF,   16'hFFFE,   1'b1},
      '{1'b1, 16'd0,      16'd4,      1'b1}
   };

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [W-1:0] tb_count = '0;
   logic         tb_step = 1'b0;
   logic [1:0]   mode = 2'b01;
   logic [1:0]   cap_edge = 2'b00;
   logic [1:0]   cmp_act = 2'b00;
   logic         pwm_lowtrue = 1'b0;
   logic         val_wr = 1'b0;
   logic [W-1:0] val_wdata = '0;
   logic         flag_wr1c = 1'b0;
   logic         irq_en = 1'b0;
   logic         cap_pin = 1'b0;
   logic         ch_out, ch_flag, ch_irq;
   logic [W-1:0] val_rdata;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   ccp_channel #(.CNT_W(W), .SYNC_STAGES(2)) u_dut (
      .clk(clk), .rst_n(rst_n), .tb_count(tb_count), .tb_step(tb_step),
      .mode(mode), .cap_edge(cap_edge), .cmp_act(cmp_act),
      .pwm_lowtrue(pwm_lowtrue), .val_wr(val_wr), .val_wdata(val_wdata),
      .flag_wr1c(flag_wr1c), .irq_en(irq_en), .cap_pin(cap_pin),
      .ch_out(ch_out), .val_rdata(val_rdata), .ch_flag(ch_flag), .ch_irq(ch_irq)
   );

   task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
      n_cmp++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %0h expected %0h", req, got, exp);
      end
   endtask

   task automatic step(input logic [W-1:0] c);
      tb_count = c;
      tb_step  = 1'b1;
      @(negedge clk);
      tb_step  = 1'b0;
   endtask

   task automatic bus_write(input logic [W-1:0] v);
      val_wr    = 1'b1;
      val_wdata = v;
      @(negedge clk);
      val_wr    = 1'b0;
   endtask

   task automatic clear_flag();
      flag_wr1c = 1'b1;
      @(negedge clk);
      flag_wr1c = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      @(negedge clk);
      // R11 reset state
      check("R11 out", ch_out, 0);
      check("R11 flag", ch_flag, 0);
      check("R11 irq", ch_irq, 0);
      check("R11 rdata", val_rdata, 0);

      // R10 direct write in compare mode
      bus_write(16'd100);
      check("R10 direct write", val_rdata, 16'd100);

      // R3 set action, R8 flag, R9 irq gating
      cmp_act = 2'b11;
      step(16'd100);
      check("R3 set", ch_out, 1);
      check("R8 flag on match", ch_flag, 1);
      check("R9 irq masked", ch_irq, 0);
      irq_en = 1'b1;
      @(negedge clk);
      check("R9 irq enabled", ch_irq, 1);
      clear_flag();
      check("R8 flag cleared", ch_flag, 0);
      check("R9 irq after clear", ch_irq, 0);

      // R3 toggle, no match, clear, hold
      cmp_act = 2'b01;
      step(16'd100);
      check("R3 toggle low", ch_out, 0);
      clear_flag();
      step(16'd99);
      check("R3 no match out", ch_out, 0);
      check("R8 no match flag", ch_flag, 0);
      step(16'd100);
      check("R3 toggle high", ch_out, 1);
      cmp_act = 2'b10;
      step(16'd100);
      check("R3 clear", ch_out, 0);
      cmp_act = 2'b11;
      step(16'd100);
      cmp_act = 2'b00;
      step(16'd100);
      check("R3 hold", ch_out, 1);

      // R8 set wins over clear in same cycle
      tb_count  = 16'd100;
      tb_step   = 1'b1;
      flag_wr1c = 1'b1;
      @(negedge clk);
      tb_step   = 1'b0;
      flag_wr1c = 1'b0;
      check("R8 set beats clear", ch_flag, 1);
      clear_flag();

      // R4 table of PWM vectors
      mode = 2'b10;
      for (int i = 0; i < 8; i++) begin
         pwm_lowtrue = VEC[i].lt;
         bus_write(VEC[i].val);
         step(16'd0);
         step(VEC[i].cnt);
         check($sformatf("R4 vector %0d", i), ch_out, VEC[i].exp);
      end

      // R6 buffering, R1 readback of holding register
      pwm_lowtrue = 1'b0;
      bus_write(16'd20);
      check("R1 pwm readback", val_rdata, 16'd20);
      step(16'd5);
      check("R6 old value still active", ch_out, 0);
      step(16'd0);
      check("R6 loaded at zero", ch_out, 1);
      step(16'd19);
      check("R6 below new value", ch_out, 1);
      step(16'd20);
      check("R6 at new value", ch_out, 0);

      // R5 duty extremes
      bus_write(16'hFFFF);
      step(16'd0);
      check("R5 full duty 0", ch_out, 1);
      step(16'h7FFF);
      check("R5 full duty mid", ch_out, 1);
      step(16'hFFFE);
      check("R5 full duty top", ch_out, 1);
      bus_write(16'd0);
      step(16'd0);
      check("R5 zero duty 0", ch_out, 0);
      step(16'd1);
      check("R5 zero duty 1", ch_out, 0);
      pwm_lowtrue = 1'b1;
      step(16'd2);
      check("R5 zero duty low-true", ch_out, 1);
      pwm_lowtrue = 1'b0;

      // R7 center-aligned with up/down count
      bus_write(16'd3);
      begin
         int ups = 0;
         int downs = 0;
         logic [W-1:0] seq [11] = '{0, 1, 2, 3, 4, 5, 4, 3, 2, 1, 0};
         logic         exp [11] = '{1, 1, 1, 0, 0, 0, 0, 0, 1, 1, 1};
         for (int i = 0; i < 11; i++) begin
            step(seq[i]);
            check($sformatf("R7 center count %0d", seq[i]), ch_out, exp[i]);
            if (ch_out && i < 5) ups++;
            if (ch_out && i > 5) downs++;
         end
         check("R7 symmetric slopes", ups, downs);
      end

      // R2 capture: rising
      mode = 2'b00;
      clear_flag();
      cap_edge = 2'b01;
      tb_count = 16'd1234;
      cap_pin  = 1'b1;
      idle(3);
      check("R2 rising capture", val_rdata, 16'd1234);
      check("R8 flag on capture", ch_flag, 1);
      check("R1 capture readback active", val_rdata, 16'd1234);
      clear_flag();
      // R2 falling ignored when rising selected
      tb_count = 16'd2000;
      cap_pin  = 1'b0;
      idle(4);
      check("R2 falling ignored value", val_rdata, 16'd1234);
      check("R2 falling ignored flag", ch_flag, 0);
      // R2 both edges, exact latency with a moving count
      cap_edge = 2'b11;
      cap_pin  = 1'b1;
      tb_count = 16'd3000;
      @(negedge clk);
      tb_count = 16'd3001;
      @(negedge clk);
      tb_count = 16'd3002;
      check("R2 not yet captured", val_rdata, 16'd1234);
      @(negedge clk);
      check("R2 latency two edges", val_rdata, 16'd3002);
      // R2 falling edge select
      cap_edge = 2'b10;
      tb_count = 16'd4000;
      cap_pin  = 1'b0;
      idle(3);
      check("R2 falling capture", val_rdata, 16'd4000);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule